// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vector Arbiter

This block sits between the interrupt sources of a small controller and its CPU. Each source presents one request line. The block combines those lines with the CPU's global interrupt-mask bit and picks one winner. Index 0 has the highest priority, and each higher index has a lower priority. The block raises an interrupt request toward the CPU whenever any source is eligible. On the CPU's acknowledge it captures the winner's 16-bit vector address and holds it, so the CPU can fetch the service routine address from a stable value.

The two highest-priority sources cannot be masked: index 0 is reset and index 1 is the software interrupt. All other sources take part only while the mask bit is clear. Vector addresses fall in two-byte steps from a top address, which defaults to 0xFFFE. With the default 16 sources the map runs from 0xFFFE down to 0xFFE0. Where a peripheral owns several consecutive indices, as the timer group does, its lower index wins and receives the higher address.

Top module: `ivarb_top`

## Requirements
- R1: Among the eligible requests, the one with the lowest index is the winner.
- R2: The winner's vector is TOP_ADDR minus twice its index (default TOP_ADDR 0xFFFE). The default map is: 0 reset, 1 software interrupt, 2 IRQ1, 3 PLL, 4 DMA, 5–9 timer, 10–11 SPI, 12–14 SCI, 15 keyboard at 0xFFE0.
- R3: While the mask input is 1, requests at index 2 and above are not eligible.
- R4: Requests at indices 0 and 1 are eligible whatever the mask input is.
- R5: `irq_o` is 1 in the cycle after a clock edge at which some request was eligible, and 0 in the cycle after an edge at which none was.
- R6: `vec_o` takes the winner's vector at a clock edge where `ack_i` is 1 and a request is eligible. At every other edge it keeps its value, even when the requests change.
- R7: An edge with `ack_i` at 1 and no eligible request leaves `vec_o` unchanged.
- R8: During reset, `irq_o` is 0 and `vec_o` equals TOP_ADDR.
- R9: The number of sources is a parameter from 2 to 128. The priority and vector rules above hold for every value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_SRC | Request lines; index 0 has the highest priority |
| imask_i | input | 1 | Global interrupt mask from the CPU; 1 blocks indices 2 and up |
| ack_i | input | 1 | CPU acknowledge; captures the winner's vector |
| irq_o | output | 1 | Registered interrupt request to the CPU |
| vec_o | output | 16 | Captured vector address |

## Verification
The bench builds one instance with six sources at the default top address. On that instance it sweeps all 64 request patterns under both mask values, which covers every priority ordering, every masked and non-masked combination, and every case of an acknowledge with nothing eligible. A second instance uses the default sixteen sources. A walking single request there checks every vector of the full map down to 0xFFE0, and confirms that each maskable index is blocked when the mask is set.

// File: rtl/ivarb_pkg.sv
package ivarb_pkg;
  localparam int unsigned VEC_W = 16;
  localparam int unsigned NMI_CNT = 2;

  function automatic logic [VEC_W-1:0] vec_of(input logic [VEC_W-1:0] top,
                                               input int unsigned idx);
    return top - VEC_W'(idx * 2);
  endfunction
endpackage

// File: rtl/ivarb_gate.sv
module ivarb_gate #(
  parameter int unsigned N   = 16,
  parameter int unsigned NMI = 2
) (
  input  logic [N-1:0] req_i,
  input  logic         imask_i,
  output logic [N-1:0] elig_o
);
  for (genvar g = 0; g < N; g++) begin : g_src
    if (g < NMI) begin : g_nmi
      assign elig_o[g] = req_i[g];
    end else begin : g_msk
      assign elig_o[g] = req_i[g] & ~imask_i;
    end
  end
endmodule

// File: rtl/ivarb_pick.sv
module ivarb_pick #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  elig_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig_i[i]) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end

  // R1
  win_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> elig_i[idx_o]);

  // R1
  no_better_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> ((elig_i & ((N'(1) << idx_o) - N'(1))) == '0));

  // R5
  none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> (elig_i == '0));
endmodule

// File: rtl/ivarb_hold.sv
module ivarb_hold #(
  parameter int unsigned VW = 16,
  parameter logic [VW-1:0] RST_VEC = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_i,
  input  logic          ack_i,
  input  logic [VW-1:0] vec_i,
  output logic          irq_o,
  output logic [VW-1:0] vec_o
);
  logic          irq_d, irq_q;
  logic [VW-1:0] vec_d, vec_q;
  logic          vec_en;

  always_comb begin
    irq_d  = hit_i;
    vec_en = ack_i & hit_i;
    vec_d  = vec_en ? vec_i : vec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      vec_q <= RST_VEC;
    end else begin
      irq_q <= irq_d;
      vec_q <= vec_d;
    end
  end

  assign irq_o = irq_q;
  assign vec_o = vec_q;

  // R5
  irq_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(hit_i));

  // R6
  vec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && hit_i) |=> (vec_o == $past(vec_i)));

  // R6
  vec_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> $stable(vec_o));

  // R7
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !hit_i) |=> $stable(vec_o));
endmodule

// File: rtl/ivarb_top.sv
module ivarb_top
  import ivarb_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  parameter logic [15:0] TOP_ADDR = 16'hFFFE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               imask_i,
  input  logic               ack_i,
  output logic               irq_o,
  output logic [15:0]        vec_o
);
  // R9: NUM_SRC may range from 2 to 128
  localparam int unsigned IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] elig;
  logic               hit;
  logic [IW-1:0]      win_idx;
  logic [VEC_W-1:0]   win_vec;

  ivarb_gate #(.N(NUM_SRC), .NMI(NMI_CNT)) gate_i (
    .req_i   (req_i),
    .imask_i (imask_i),
    .elig_o  (elig)
  );

  ivarb_pick #(.N(NUM_SRC), .IW(IW)) pick_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .elig_i (elig),
    .hit_o  (hit),
    .idx_o  (win_idx)
  );

  assign win_vec = vec_of(TOP_ADDR, int'(win_idx));

  ivarb_hold #(.VW(VEC_W), .RST_VEC(TOP_ADDR)) hold_i (
    .clk   (clk),
    .rst_n (rst_n),
    .hit_i (hit),
    .ack_i (ack_i),
    .vec_i (win_vec),
    .irq_o (irq_o),
    .vec_o (vec_o)
  );

  // R3
  mask_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (imask_i && hit) |-> (int'(win_idx) < NMI_CNT));

  // R4
  rst_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_i[0] |-> (hit && (win_idx == '0)));

  // R2
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (win_vec <= TOP_ADDR && win_vec[0] == TOP_ADDR[0]));
endmodule

// File: tb/ivarb_top_tb_top.sv
module ivarb_top_tb_top;
  localparam int unsigned NS = 6;
  localparam int unsigned NF = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] req_s = '0;
  logic [NF-1:0] req_f = '0;
  logic msk_s = 1'b0, msk_f = 1'b0;
  logic ack_s = 1'b0, ack_f = 1'b0;
  logic irq_s, irq_f;
  logic [15:0] vec_s, vec_f;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  ivarb_top #(.NUM_SRC(NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_s), .imask_i(msk_s),
    .ack_i(ack_s), .irq_o(irq_s), .vec_o(vec_s)
  );

  ivarb_top dut_full_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_f), .imask_i(msk_f),
    .ack_i(ack_f), .irq_o(irq_f), .vec_o(vec_f)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // lowest eligible index, -1 if none
  function automatic int pick(input logic [127:0] r, input logic m, input int n);
    for (int i = 0; i < n; i++)
      if (r[i] && (!m || i < 2)) return i;
    return -1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] held;
    int w;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 irq", {15'd0, irq_s}, 16'd0);
    chk("R8 vec", vec_s, 16'hFFFE);
    chk("R8 vec full", vec_f, 16'hFFFE);
    rst_n = 1'b1;
    @(negedge clk);
    held = 16'hFFFE;
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < (1 << NS); p++) begin
        req_s = NS'(p);
        msk_s = m[0];
        ack_s = 1'b0;
        w = pick(128'(p), m[0], NS);
        @(negedge clk);
        // R5 / R3 / R4
        chk(m ? "R5 R3 R4 irq" : "R5 irq", {15'd0, irq_s}, {15'd0, w >= 0});
        ack_s = 1'b1;
        @(negedge clk);
        ack_s = 1'b0;
        if (w >= 0) held = 16'hFFFE - 16'(2 * w);
        // R1 R2 on capture, R7 when nothing eligible
        chk(w >= 0 ? "R1 R2 vec" : "R7 vec", vec_s, held);
        req_s = ~NS'(p);
        @(negedge clk);
        // R6 hold without ack
        chk("R6 hold", vec_s, held);
      end
    end
    // full map, walking request (R2 R9)
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < NF; i++) begin
        req_f = NF'(1) << i;
        msk_f = m[0];
        ack_f = 1'b1;
        @(negedge clk);
        ack_f = 1'b0;
        req_f = '0;
        if (m == 0 || i < 2) held = 16'hFFFE - 16'(2 * i);
        chk(m ? "R3 R4 R9 full" : "R2 R9 full", vec_f, held);
        chk("R5 full irq", {15'd0, irq_f}, {15'd0, (m == 0 || i < 2)});
      end
    end
    // R1 within timer group: indices 5 and 7 together, 5 wins
    req_f = NF'((1 << 5) | (1 << 7));
    msk_f = 1'b0;
    ack_f = 1'b1;
    @(negedge clk);
    ack_f = 1'b0;
    chk("R1 group", vec_f, 16'hFFF4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule